// File: doc/BRIEF.md
# Motor Start Sequencer

This block is the control state machine that decides how a three-phase motor drive gets running. It starts after a reset or after the drive wakes from a low-power mode. The sequencer does not estimate speed or run the current loop. It reads what those blocks measure: a back-EMF magnitude, a speed magnitude and a spin-direction flag. It also reads a flag saying that the bootstrap supply has passed its undervoltage threshold. From these it picks the next phase. The phase drives two things: a 2-bit override for the six power switches, and a mode request to the downstream field-oriented control loop.

The path through the sequence is set by five enables:

- speed detection
- resynchronisation
- reverse drive
- coast
- brake

A forward-spinning motor can be caught in closed loop if it is fast enough. A reverse-spinning motor can be braked electrically through zero speed and then driven forward. Otherwise the motor is coasted, braked or both, and then started in open loop. A direction-change event restarts the whole sequence unless the direction-change mode bit is set.

Top module: `mss_seq`

## Requirements
- R1: Asynchronous reset, or a one-cycle `wake_i` pulse, puts the sequencer in the power-on phase by the next clock edge. In the power-on phase, `gate_o` is 00 and `mode_o` is 0. `phase_o` is one-hot with bits 0 power-on, 1 speed detect, 2 coast, 3 brake, 4 open-loop forward, 5 closed loop, 6 reverse closed-loop deceleration, 7 reverse open-loop deceleration.
- R2: With `isd_en_i` clear, the power-on phase moves straight to the brake decision on the next edge. The brake decision means brake if `brake_en_i` is set, otherwise open-loop forward.
- R3: With `isd_en_i` set, the power-on phase stays in place while `boot_ok_i` is low. It enters speed detect on the first edge where `boot_ok_i` is high.
- R4: In speed detect, `bemf_i < stat_thr_i` means the motor is stationary. The sequencer then goes to the brake decision.
- R5: A moving forward motor (`spin_rev_i`=0) with `resync_en_i` set goes to closed loop if `speed_i > resync_thr_i`, and to open-loop forward otherwise. With `resync_en_i` clear it goes to the coast decision. The coast decision means coast if `coast_en_i` is set, otherwise the brake decision.
- R6: A moving reverse motor with `rvs_en_i` set goes to reverse closed-loop deceleration if `speed_i > handoff_thr_i`, and to reverse open-loop deceleration otherwise. With `rvs_en_i` clear it goes to the coast decision.
- R7: Reverse closed-loop deceleration lasts while `spin_rev_i`=1 and `speed_i > handoff_thr_i`, then moves to reverse open-loop deceleration. That phase moves to open-loop forward once `spin_rev_i` clears. Open-loop forward moves to closed loop once `spin_rev_i`=0 and `speed_i > resync_thr_i`.
- R8: Coast holds `gate_o`=01 (all switches off) for `coast_time_i`+1 cycles, then takes the brake decision. A time of 0 gives one cycle.
- R9: Brake holds `gate_o`=10 (low-side switches on) for `brake_time_i`+1 cycles, then goes to open-loop forward.
- R10: `dir_chg_i`=1 with `dir_mode_i`=0 returns the sequencer to power-on on the next edge from any phase. With `dir_mode_i`=1 the event is ignored.
- R11: `gate_o` is 00 outside coast and brake and is never 11. `mode_o` takes these values:

  | `mode_o` | Phases |
  |---|---|
  | 0 | power-on, coast, brake |
  | 1 | open-loop forward |
  | 2 | closed loop |
  | 3 | reverse closed-loop deceleration |
  | 4 | reverse open-loop deceleration |
  | 5 | speed detect |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wake_i | input | 1 | Pulse on leaving standby or sleep |
| isd_en_i | input | 1 | Enable initial speed detection |
| resync_en_i | input | 1 | Enable forward resynchronisation |
| rvs_en_i | input | 1 | Enable reverse-drive deceleration |
| coast_en_i | input | 1 | Enable coast phase |
| brake_en_i | input | 1 | Enable brake phase |
| dir_mode_i | input | 1 | 1 = ignore direction-change events |
| dir_chg_i | input | 1 | Direction-change event |
| boot_ok_i | input | 1 | Bootstrap supply above undervoltage level |
| spin_rev_i | input | 1 | Motor spinning in reverse |
| bemf_i | input | SPD_W | Measured back-EMF magnitude |
| stat_thr_i | input | SPD_W | Stationary threshold |
| speed_i | input | SPD_W | Speed magnitude |
| resync_thr_i | input | SPD_W | Forward closed-loop handoff speed |
| handoff_thr_i | input | SPD_W | Reverse closed-loop handoff speed |
| coast_time_i | input | TIME_W | Coast duration minus one, in cycles |
| brake_time_i | input | TIME_W | Brake duration minus one, in cycles |
| phase_o | output | 8 | One-hot current phase |
| gate_o | output | 2 | Switch override code |
| mode_o | output | 3 | Mode request to control loop |

## Verification
The bound checker watches the following on every cycle:
- `phase_o` stays one-hot and `gate_o` never shows the code 11.
- A direction-change event in mode 0, or a wake pulse, always lands in power-on.
- Speed detect is entered only after a cycle with the bootstrap flag high.
- Coast and brake are left only toward their permitted successors.
- Closed loop is entered only from speed detect or open-loop forward.

Only the directed scenarios can show the following:
- the threshold comparisons and which way each decision branch goes;
- exact coast and brake durations, including the zero-time case;
- the full reverse path through zero speed;
- that a direction change with the mode bit set leaves closed loop undisturbed.

// File: rtl/mss_pkg.sv
package mss_pkg;
  typedef enum logic [2:0] {
    ST_PWRON    = 3'd0,
    ST_ISD      = 3'd1,
    ST_COAST    = 3'd2,
    ST_BRAKE    = 3'd3,
    ST_OPEN_FWD = 3'd4,
    ST_CLOSED   = 3'd5,
    ST_REV_CL   = 3'd6,
    ST_REV_OL   = 3'd7
  } mss_state_e;

  localparam int unsigned NUM_ST = 8;

  localparam logic [1:0] GATE_NONE = 2'b00;
  localparam logic [1:0] GATE_OFF  = 2'b01;
  localparam logic [1:0] GATE_LOW  = 2'b10;

  localparam logic [2:0] MODE_HOLD   = 3'd0;
  localparam logic [2:0] MODE_OL_FWD = 3'd1;
  localparam logic [2:0] MODE_CL_FWD = 3'd2;
  localparam logic [2:0] MODE_REV_CL = 3'd3;
  localparam logic [2:0] MODE_REV_OL = 3'd4;
  localparam logic [2:0] MODE_DETECT = 3'd5;
endpackage

// File: rtl/mss_timer.sv
module mss_timer #(
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] val_i,
  input  logic              run_i,
  output logic              zero_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mss_next.sv
module mss_next
  import mss_pkg::*;
#(
  parameter int unsigned SPD_W  = 16,
  parameter int unsigned TIME_W = 16
) (
  input  mss_state_e        state_i,
  input  logic              restart_i,
  input  logic              isd_en_i,
  input  logic              resync_en_i,
  input  logic              rvs_en_i,
  input  logic              coast_en_i,
  input  logic              brake_en_i,
  input  logic              boot_ok_i,
  input  logic              spin_rev_i,
  input  logic [SPD_W-1:0]  bemf_i,
  input  logic [SPD_W-1:0]  stat_thr_i,
  input  logic [SPD_W-1:0]  speed_i,
  input  logic [SPD_W-1:0]  resync_thr_i,
  input  logic [SPD_W-1:0]  handoff_thr_i,
  input  logic [TIME_W-1:0] coast_time_i,
  input  logic [TIME_W-1:0] brake_time_i,
  input  logic              tmr_zero_i,
  output mss_state_e        nxt_o,
  output logic              load_o,
  output logic [TIME_W-1:0] load_val_o
);
  mss_state_e brake_tgt, coast_tgt, fwd_tgt, rev_tgt;
  logic fast_fwd, fast_rev;

  always_comb begin
    fast_fwd  = speed_i > resync_thr_i;
    fast_rev  = speed_i > handoff_thr_i;
    brake_tgt = brake_en_i  ? ST_BRAKE : ST_OPEN_FWD;
    coast_tgt = coast_en_i  ? ST_COAST : brake_tgt;
    fwd_tgt   = resync_en_i ? (fast_fwd ? ST_CLOSED : ST_OPEN_FWD) : coast_tgt;
    rev_tgt   = rvs_en_i    ? (fast_rev ? ST_REV_CL : ST_REV_OL)   : coast_tgt;

    nxt_o = state_i;
    unique case (state_i)
      ST_PWRON: begin
        if (!isd_en_i)     nxt_o = brake_tgt;
        else if (boot_ok_i) nxt_o = ST_ISD;
      end
      ST_ISD: begin
        if (bemf_i < stat_thr_i) nxt_o = brake_tgt;
        else if (spin_rev_i)     nxt_o = rev_tgt;
        else                     nxt_o = fwd_tgt;
      end
      ST_COAST:    if (tmr_zero_i) nxt_o = brake_tgt;
      ST_BRAKE:    if (tmr_zero_i) nxt_o = ST_OPEN_FWD;
      ST_OPEN_FWD: if (!spin_rev_i && fast_fwd) nxt_o = ST_CLOSED;
      ST_CLOSED:   nxt_o = ST_CLOSED;
      ST_REV_CL:   if (!(spin_rev_i && fast_rev)) nxt_o = ST_REV_OL;
      ST_REV_OL:   if (!spin_rev_i) nxt_o = ST_OPEN_FWD;
      default:     nxt_o = ST_PWRON;
    endcase
    if (restart_i) nxt_o = ST_PWRON;

    load_o     = (nxt_o != state_i) && (nxt_o == ST_COAST || nxt_o == ST_BRAKE);
    load_val_o = (nxt_o == ST_COAST) ? coast_time_i : brake_time_i;
  end
endmodule

// File: rtl/mss_out.sv
module mss_out
  import mss_pkg::*;
(
  input  mss_state_e        state_i,
  output logic [NUM_ST-1:0] phase_o,
  output logic [1:0]        gate_o,
  output logic [2:0]        mode_o
);
  for (genvar i = 0; i < NUM_ST; i++) begin : g_phase
    assign phase_o[i] = (state_i == mss_state_e'(i));
  end

  always_comb begin
    gate_o = GATE_NONE;
    mode_o = MODE_HOLD;
    unique case (state_i)
      ST_COAST:    gate_o = GATE_OFF;
      ST_BRAKE:    gate_o = GATE_LOW;
      ST_ISD:      mode_o = MODE_DETECT;
      ST_OPEN_FWD: mode_o = MODE_OL_FWD;
      ST_CLOSED:   mode_o = MODE_CL_FWD;
      ST_REV_CL:   mode_o = MODE_REV_CL;
      ST_REV_OL:   mode_o = MODE_REV_OL;
      default:     ;
    endcase
  end
endmodule

// File: rtl/mss_seq.sv
module mss_seq
  import mss_pkg::*;
#(
  parameter int unsigned SPD_W  = 16,
  parameter int unsigned TIME_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wake_i,
  input  logic              isd_en_i,
  input  logic              resync_en_i,
  input  logic              rvs_en_i,
  input  logic              coast_en_i,
  input  logic              brake_en_i,
  input  logic              dir_mode_i,
  input  logic              dir_chg_i,
  input  logic              boot_ok_i,
  input  logic              spin_rev_i,
  input  logic [SPD_W-1:0]  bemf_i,
  input  logic [SPD_W-1:0]  stat_thr_i,
  input  logic [SPD_W-1:0]  speed_i,
  input  logic [SPD_W-1:0]  resync_thr_i,
  input  logic [SPD_W-1:0]  handoff_thr_i,
  input  logic [TIME_W-1:0] coast_time_i,
  input  logic [TIME_W-1:0] brake_time_i,
  output logic [NUM_ST-1:0] phase_o,
  output logic [1:0]        gate_o,
  output logic [2:0]        mode_o
);
  mss_state_e        state_q, state_d;
  logic              restart, tmr_load, tmr_zero, tmr_run;
  logic [TIME_W-1:0] tmr_val;

  assign restart = wake_i || (dir_chg_i && !dir_mode_i);
  assign tmr_run = (state_q == ST_COAST) || (state_q == ST_BRAKE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PWRON;
    else         state_q <= state_d;
  end

  mss_next #(.SPD_W(SPD_W), .TIME_W(TIME_W)) u_next (
    .state_i      (state_q),
    .restart_i    (restart),
    .isd_en_i     (isd_en_i),
    .resync_en_i  (resync_en_i),
    .rvs_en_i     (rvs_en_i),
    .coast_en_i   (coast_en_i),
    .brake_en_i   (brake_en_i),
    .boot_ok_i    (boot_ok_i),
    .spin_rev_i   (spin_rev_i),
    .bemf_i       (bemf_i),
    .stat_thr_i   (stat_thr_i),
    .speed_i      (speed_i),
    .resync_thr_i (resync_thr_i),
    .handoff_thr_i(handoff_thr_i),
    .coast_time_i (coast_time_i),
    .brake_time_i (brake_time_i),
    .tmr_zero_i   (tmr_zero),
    .nxt_o        (state_d),
    .load_o       (tmr_load),
    .load_val_o   (tmr_val)
  );

  mss_timer #(.TIME_W(TIME_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tmr_load),
    .val_i (tmr_val),
    .run_i (tmr_run),
    .zero_o(tmr_zero)
  );

  mss_out u_out (
    .state_i(state_q),
    .phase_o(phase_o),
    .gate_o (gate_o),
    .mode_o (mode_o)
  );
endmodule

// File: rtl/mss_seq_chk.sv
module mss_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wake_i,
  input logic       dir_chg_i,
  input logic       dir_mode_i,
  input logic       boot_ok_i,
  input logic       isd_en_i,
  input logic [7:0] phase_o,
  input logic [1:0] gate_o
);
  logic restart;
  assign restart = wake_i || (dir_chg_i && !dir_mode_i);

  a_r10_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_chg_i && !dir_mode_i) |=> phase_o[0]);

  a_r1_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_i |=> phase_o[0]);

  a_r3_boot_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o[1]) |-> $past(boot_ok_i && isd_en_i));

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(phase_o));

  a_r11_gate_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o != 2'b11);

  a_r8_coast_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(phase_o[2]) && !$past(restart)) |-> (phase_o[3] || phase_o[4]));

  a_r9_brake_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(phase_o[3]) && !$past(restart)) |-> phase_o[4]);

  a_r5_closed_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_o[5]) |-> $past(phase_o[1] || phase_o[4]));
endmodule

bind mss_seq mss_seq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wake_i    (wake_i),
  .dir_chg_i (dir_chg_i),
  .dir_mode_i(dir_mode_i),
  .boot_ok_i (boot_ok_i),
  .isd_en_i  (isd_en_i),
  .phase_o   (phase_o),
  .gate_o    (gate_o)
);

// File: tb/mss_seq_tb.sv
module mss_seq_tb;
  localparam int SPD_W = 16, TIME_W = 16;
  localparam logic [7:0] P_PWRON = 8'h01, P_ISD = 8'h02, P_COAST = 8'h04, P_BRAKE = 8'h08;
  localparam logic [7:0] P_OFWD = 8'h10, P_CL = 8'h20, P_RCL = 8'h40, P_ROL = 8'h80;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wake, isd_en, resync_en, rvs_en, coast_en, brake_en, dir_mode, dir_chg, boot_ok, spin_rev;
  logic [SPD_W-1:0] bemf, stat_thr, speed, resync_thr, handoff_thr;
  logic [TIME_W-1:0] coast_time, brake_time;
  logic [7:0] phase;
  logic [1:0] gate;
  logic [2:0] mode;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mss_seq #(.SPD_W(SPD_W), .TIME_W(TIME_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wake_i(wake), .isd_en_i(isd_en),
    .resync_en_i(resync_en), .rvs_en_i(rvs_en), .coast_en_i(coast_en),
    .brake_en_i(brake_en), .dir_mode_i(dir_mode), .dir_chg_i(dir_chg),
    .boot_ok_i(boot_ok), .spin_rev_i(spin_rev), .bemf_i(bemf),
    .stat_thr_i(stat_thr), .speed_i(speed), .resync_thr_i(resync_thr),
    .handoff_thr_i(handoff_thr), .coast_time_i(coast_time),
    .brake_time_i(brake_time), .phase_o(phase), .gate_o(gate), .mode_o(mode)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic defaults();
    wake = 0; isd_en = 1; resync_en = 0; rvs_en = 0; coast_en = 0; brake_en = 0;
    dir_mode = 0; dir_chg = 0; boot_ok = 1; spin_rev = 0;
    bemf = 100; stat_thr = 20; speed = 50; resync_thr = 200; handoff_thr = 80;
    coast_time = 0; brake_time = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic t_reset_boot();
    defaults(); boot_ok = 0; bemf = 5;
    do_reset();
    chk("R1", "reset phase", phase, P_PWRON);
    chk("R1", "reset gate", gate, 0);
    chk("R1", "reset mode", mode, 0);
    step(); step();
    chk("R3", "waits for boot", phase, P_PWRON);
    boot_ok = 1; step();
    chk("R3", "enters detect", phase, P_ISD);
    chk("R11", "detect mode", mode, 5);
    step();
    chk("R4", "stationary to start", phase, P_OFWD);
    chk("R11", "open fwd mode", mode, 1);
  endtask

  task automatic t_isd_off_brake();
    defaults(); isd_en = 0; boot_ok = 0; brake_en = 1; brake_time = 2;
    do_reset(); step();
    chk("R2", "skip detect to brake", phase, P_BRAKE);
    chk("R9", "brake gate", gate, 2);
    step(); step();
    chk("R9", "brake 3rd cycle", phase, P_BRAKE);
    step();
    chk("R9", "after brake", phase, P_OFWD);
    chk("R11", "gate released", gate, 0);
  endtask

  task automatic t_resync();
    defaults(); resync_en = 1; speed = 300;
    do_reset(); step(); step();
    chk("R5", "fast fwd resync", phase, P_CL);
    chk("R11", "closed mode", mode, 2);
    speed = 200; do_reset(); step(); step();
    chk("R5", "slow fwd open loop", phase, P_OFWD);
    step();
    chk("R7", "open fwd holds", phase, P_OFWD);
    speed = 201; step();
    chk("R7", "open fwd to closed", phase, P_CL);
  endtask

  task automatic t_coast();
    defaults(); coast_en = 1; coast_time = 3; brake_en = 1; brake_time = 0;
    do_reset(); step(); step();
    chk("R8", "coast entry", phase, P_COAST);
    chk("R8", "coast gate", gate, 1);
    step(); step(); step();
    chk("R8", "coast 4th cycle", phase, P_COAST);
    step();
    chk("R8", "coast to brake", phase, P_BRAKE);
    step();
    chk("R9", "zero brake one cycle", phase, P_OFWD);
    coast_time = 0; brake_en = 0;
    do_reset(); step(); step();
    chk("R8", "zero coast entry", phase, P_COAST);
    step();
    chk("R8", "zero coast one cycle", phase, P_OFWD);
  endtask

  task automatic t_reverse();
    defaults(); rvs_en = 1; spin_rev = 1; speed = 150; resync_thr = 120;
    do_reset(); step(); step();
    chk("R6", "fast rev closed decel", phase, P_RCL);
    chk("R11", "rev cl mode", mode, 3);
    speed = 90; step();
    chk("R7", "rev cl holds", phase, P_RCL);
    speed = 80; step();
    chk("R7", "rev cl to ol", phase, P_ROL);
    chk("R11", "rev ol mode", mode, 4);
    speed = 0; step();
    chk("R7", "rev ol holds", phase, P_ROL);
    spin_rev = 0; step();
    chk("R7", "zero cross to fwd", phase, P_OFWD);
    speed = 121; step();
    chk("R7", "fwd to closed", phase, P_CL);
    spin_rev = 1; speed = 80; do_reset(); step(); step();
    chk("R6", "slow rev open decel", phase, P_ROL);
    rvs_en = 0; do_reset(); step(); step();
    chk("R6", "rev disabled to start", phase, P_OFWD);
  endtask

  task automatic t_dir_change();
    defaults(); resync_en = 1; speed = 300;
    do_reset(); step(); step();
    chk("R10", "in closed", phase, P_CL);
    dir_mode = 1; dir_chg = 1; step(); dir_chg = 0;
    chk("R10", "ignored with mode 1", phase, P_CL);
    dir_mode = 0; dir_chg = 1; step(); dir_chg = 0;
    chk("R10", "restart from closed", phase, P_PWRON);
    step(); step();
    chk("R10", "reruns sequence", phase, P_CL);
    wake = 1; step(); wake = 0;
    chk("R1", "wake restart", phase, P_PWRON);
    resync_en = 0; coast_en = 1; coast_time = 10;
    do_reset(); step(); step(); step();
    dir_chg = 1; step(); dir_chg = 0;
    chk("R10", "restart from coast", phase, P_PWRON);
    chk("R10", "gate after restart", gate, 0);
  endtask

  initial begin
    defaults();
    t_reset_boot();
    t_isd_off_brake();
    t_resync();
    t_coast();
    t_reverse();
    t_dir_change();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule